// File: doc/BRIEF.md
# In-Flight Merged Request Table

This block keeps track of merged memory requests that are still waiting for their response. Whenever a merged request goes out, a row is allocated. The row is tagged with the source ID given to the merged request. For every lane it stores a fixed number of original-request slots. Each slot holds its own valid bit, the original requester's source ID, a byte offset and a two-bit size code. Later a response arrives carrying a source ID. The table is searched on that ID, and the matching row's contents are returned in the same cycle so the response can be split back to the original lanes. The row is released at the following clock edge.

Allocation and lookup-with-release are independent ports and may both fire in one cycle. Allocation fills the lowest-indexed empty row and is refused only while every row is occupied. The number of slots per lane is a parameter of its own and is not tied to the source-ID width.

Top module: `inflight_table`

## Requirements
- R1: After reset no row is occupied: `allocReady` is 1, and a lookup on any key, including key 0, reports `lookupHit` = 0.
- R2: `allocReady` is 1 exactly when fewer than ROWS rows are occupied. An allocation offered while it is 0 is dropped and leaves no row behind.
- R3: When `lookupValid` is 1 and an occupied row holds `lookupKey`, `lookupHit` is 1 in the same cycle. The row's stored slot fields appear on the read ports, bit for bit as they were written.
- R4: A row that is not occupied never produces a hit, even if its stored key equals `lookupKey`. On a miss every read port is all zeros.
- R5: A hit releases its row at the next clock edge, so an identical lookup after that edge misses.
- R6: An allocation and a hit in the same cycle both take effect: the new row becomes occupied and the hit row is released.
- R7: Slot fields are packed with slot s = lane*PER_LANE + k. The valid bit is at bit s of the slot-valid vector. The old source ID, offset and size each sit in field s of their vectors, counted from bit 0. Slots written with a clear valid bit read back with that bit clear. Every slot keeps its own old source ID. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R8: While `lookupValid` is 0, `lookupHit` is 0 and no row is released.
- R9: When several occupied rows hold the same key, a lookup returns the lowest-indexed one. Repeated lookups return the remaining rows in index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Request to record a new merged request |
| allocReady | output | 1 | A free row exists |
| allocKey | input | KEY_W | Source ID of the merged request |
| allocSlotValid | input | SLOTS | Per-slot occupied bits |
| allocOldSrc | input | SLOTS*OLD_W | Per-slot original source IDs |
| allocOffset | input | SLOTS*OFF_W | Per-slot byte offsets |
| allocSize | input | SLOTS*2 | Per-slot size codes |
| lookupValid | input | 1 | Response present; search and release |
| lookupKey | input | KEY_W | Source ID carried by the response |
| lookupHit | output | 1 | An occupied row matches |
| rdSlotValid | output | SLOTS | Matching row's slot valid bits |
| rdOldSrc | output | SLOTS*OLD_W | Matching row's original source IDs |
| rdOffset | output | SLOTS*OFF_W | Matching row's offsets |
| rdSize | output | SLOTS*2 | Matching row's size codes |

## Verification
The hardest case to reach is a lookup that lands on a row whose stored key still matches although the row has been released. Two kinds of stimulus produce it. The first is a lookup of key 0 straight out of reset, when every stored key is zero. The second is a repeat lookup of a key right after its own release. Allocation and release in one cycle only matter when the table is partly full, so the stimulus first fills every row, then frees one and issues a merged allocation and lookup together. A closing random run with a narrow key range keeps producing duplicate keys, near-full states and same-cycle traffic, all checked against a row model kept in the bench.

// File: rtl/ift_pkg.sv
package ift_pkg;
  localparam int SIZE_W = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } sizeCode_e;

  typedef struct packed {
    logic wrEn;   // write the chosen free row this edge
    logic clrEn;  // matching row is read now and released this edge
  } tableStrobe_t;
endpackage

// File: rtl/ift_ctrl.sv
module ift_ctrl
  import ift_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int KEY_W = 4,
  localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  allocValid,
  input  logic                  lookupValid,
  input  logic [KEY_W-1:0]      lookupKey,
  input  logic [ROWS*KEY_W-1:0] rowKeys,
  output logic                  allocReady,
  output logic                  lookupHit,
  output tableStrobe_t          strobe,
  output logic [IDX_W-1:0]      wrIdx,
  output logic [IDX_W-1:0]      hitIdx,
  output logic [ROWS-1:0]       rowValid
);
  logic [ROWS-1:0] matchVec;

  for (genvar r = 0; r < ROWS; r++) begin : g_match
    assign matchVec[r] = rowValid[r] && (rowKeys[r*KEY_W +: KEY_W] == lookupKey);
  end

  always_comb begin
    wrIdx = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (!rowValid[r]) wrIdx = IDX_W'(r);
    end
  end

  always_comb begin
    hitIdx = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (matchVec[r]) hitIdx = IDX_W'(r);
    end
  end

  assign allocReady   = ~&rowValid;
  assign lookupHit    = lookupValid && (|matchVec);
  assign strobe.wrEn  = allocValid && allocReady;
  assign strobe.clrEn = lookupHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowValid <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (strobe.wrEn && (wrIdx == IDX_W'(r)))
          rowValid[r] <= 1'b1;            // allocation wins over release
        else if (strobe.clrEn && (hitIdx == IDX_W'(r)))
          rowValid[r] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ift_data.sv
module ift_data
  import ift_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int SLOTS = 8,
  parameter int KEY_W = 4,
  parameter int OLD_W = 3,
  parameter int OFF_W = 4,
  localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int PAY_W = SLOTS * (1 + OLD_W + OFF_W + SIZE_W)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tableStrobe_t            strobe,
  input  logic [IDX_W-1:0]        wrIdx,
  input  logic [IDX_W-1:0]        hitIdx,
  input  logic [KEY_W-1:0]        allocKey,
  input  logic [SLOTS-1:0]        allocSlotValid,
  input  logic [SLOTS*OLD_W-1:0]  allocOldSrc,
  input  logic [SLOTS*OFF_W-1:0]  allocOffset,
  input  logic [SLOTS*SIZE_W-1:0] allocSize,
  output logic [ROWS*KEY_W-1:0]   rowKeys,
  output logic [SLOTS-1:0]        rdSlotValid,
  output logic [SLOTS*OLD_W-1:0]  rdOldSrc,
  output logic [SLOTS*OFF_W-1:0]  rdOffset,
  output logic [SLOTS*SIZE_W-1:0] rdSize
);
  logic [KEY_W-1:0] keyMem [ROWS];
  logic [PAY_W-1:0] payMem [ROWS];
  logic [PAY_W-1:0] payIn;
  logic [PAY_W-1:0] payOut;

  assign payIn = {allocSize, allocOffset, allocOldSrc, allocSlotValid};

  for (genvar r = 0; r < ROWS; r++) begin : g_keys
    assign rowKeys[r*KEY_W +: KEY_W] = keyMem[r];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) begin
        keyMem[r] <= '0;
        payMem[r] <= '0;
      end
    end else if (strobe.wrEn) begin
      keyMem[wrIdx] <= allocKey;
      payMem[wrIdx] <= payIn;
    end
  end

  assign payOut = strobe.clrEn ? payMem[hitIdx] : '0;
  assign {rdSize, rdOffset, rdOldSrc, rdSlotValid} = payOut;
endmodule

// File: rtl/inflight_table.sv
module inflight_table
  import ift_pkg::*;
#(
  parameter int ROWS     = 4,
  parameter int LANES    = 4,
  parameter int PER_LANE = 2,
  parameter int KEY_W    = 4,
  parameter int OLD_W    = 3,
  parameter int OFF_W    = 4,
  localparam int SLOTS   = LANES * PER_LANE,
  localparam int IDX_W   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    allocValid,
  output logic                    allocReady,
  input  logic [KEY_W-1:0]        allocKey,
  input  logic [SLOTS-1:0]        allocSlotValid,
  input  logic [SLOTS*OLD_W-1:0]  allocOldSrc,
  input  logic [SLOTS*OFF_W-1:0]  allocOffset,
  input  logic [SLOTS*2-1:0]      allocSize,
  input  logic                    lookupValid,
  input  logic [KEY_W-1:0]        lookupKey,
  output logic                    lookupHit,
  output logic [SLOTS-1:0]        rdSlotValid,
  output logic [SLOTS*OLD_W-1:0]  rdOldSrc,
  output logic [SLOTS*OFF_W-1:0]  rdOffset,
  output logic [SLOTS*2-1:0]      rdSize
);
  tableStrobe_t          strobe;
  logic [IDX_W-1:0]      wrIdx;
  logic [IDX_W-1:0]      hitIdx;
  logic [ROWS-1:0]       rowValid;
  logic [ROWS*KEY_W-1:0] rowKeys;

  ift_ctrl #(.ROWS(ROWS), .KEY_W(KEY_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .lookupValid(lookupValid), .lookupKey(lookupKey),
    .rowKeys(rowKeys), .allocReady(allocReady), .lookupHit(lookupHit),
    .strobe(strobe), .wrIdx(wrIdx), .hitIdx(hitIdx), .rowValid(rowValid)
  );

  ift_data #(.ROWS(ROWS), .SLOTS(SLOTS), .KEY_W(KEY_W), .OLD_W(OLD_W), .OFF_W(OFF_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .hitIdx(hitIdx),
    .allocKey(allocKey), .allocSlotValid(allocSlotValid), .allocOldSrc(allocOldSrc),
    .allocOffset(allocOffset), .allocSize(allocSize), .rowKeys(rowKeys),
    .rdSlotValid(rdSlotValid), .rdOldSrc(rdOldSrc), .rdOffset(rdOffset), .rdSize(rdSize)
  );
endmodule

// File: rtl/ift_checker.sv
module ift_checker #(
  parameter int ROWS = 4,
  localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CNT_W = $clog2(ROWS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocValid,
  input logic             allocReady,
  input logic             lookupValid,
  input logic             lookupHit,
  input logic [ROWS-1:0]  rowValid,
  input logic [IDX_W-1:0] hitIdx
);
  logic [CNT_W-1:0] liveCnt;

  always_ff @(posedge clk) begin
    if (!rstN) liveCnt <= '0;
    else liveCnt <= liveCnt + CNT_W'(allocValid && allocReady) - CNT_W'(lookupHit);
  end

  assert_ready_tracks_R2: assert property (@(posedge clk) disable iff (!rstN)
    allocReady == (liveCnt != CNT_W'(ROWS)));

  assert_occupancy_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rowValid) == int'(liveCnt));

  assert_hit_live_row_R4: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit |-> rowValid[hitIdx]);

  assert_hit_released_R5: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit |=> !rowValid[$past(hitIdx)]);

  assert_hit_needs_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit |-> lookupValid);
endmodule

bind inflight_table ift_checker #(.ROWS(ROWS)) u_ift_checker (
  .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocReady(allocReady),
  .lookupValid(lookupValid), .lookupHit(lookupHit), .rowValid(rowValid), .hitIdx(hitIdx)
);

// File: tb/test_inflight_table.sv
module test_inflight_table;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 4;
  localparam int SLOTS = 8;
  localparam int KEY_W = 4;
  localparam int OLD_W = 3;
  localparam int OFF_W = 4;
  localparam int PAY_W = SLOTS * (1 + OLD_W + OFF_W + 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 1'b0;
  logic allocReady;
  logic [KEY_W-1:0] allocKey = '0;
  logic [SLOTS-1:0] allocSlotValid = '0;
  logic [SLOTS*OLD_W-1:0] allocOldSrc = '0;
  logic [SLOTS*OFF_W-1:0] allocOffset = '0;
  logic [SLOTS*2-1:0] allocSize = '0;
  logic lookupValid = 1'b0;
  logic [KEY_W-1:0] lookupKey = '0;
  logic lookupHit;
  logic [SLOTS-1:0] rdSlotValid;
  logic [SLOTS*OLD_W-1:0] rdOldSrc;
  logic [SLOTS*OFF_W-1:0] rdOffset;
  logic [SLOTS*2-1:0] rdSize;

  always #(CLK_PERIOD/2) clk = ~clk;

  inflight_table i_inflight_table (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocReady(allocReady),
    .allocKey(allocKey), .allocSlotValid(allocSlotValid), .allocOldSrc(allocOldSrc),
    .allocOffset(allocOffset), .allocSize(allocSize), .lookupValid(lookupValid),
    .lookupKey(lookupKey), .lookupHit(lookupHit), .rdSlotValid(rdSlotValid),
    .rdOldSrc(rdOldSrc), .rdOffset(rdOffset), .rdSize(rdSize)
  );

  typedef struct {
    logic ready;
    logic hit;
    logic [PAY_W-1:0] pay;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic mValid [ROWS];
  logic [KEY_W-1:0] mKey [ROWS];
  logic [PAY_W-1:0] mPay [ROWS];

  function automatic logic [PAY_W-1:0] mkPay(input logic [SLOTS-1:0] sv);
    logic [PAY_W-1:0] p;
    p = PAY_W'({$urandom, $urandom, $urandom});
    p[SLOTS-1:0] = sv;
    return p;
  endfunction

  task automatic step(input logic aV, input logic [KEY_W-1:0] aK, input logic [PAY_W-1:0] aP,
                      input logic lV, input logic [KEY_W-1:0] lK, input string tag);
    expItem_t it;
    int cnt;
    int hitRow;
    int freeRow;
    @(negedge clk);
    allocValid = aV;
    allocKey = aK;
    {allocSize, allocOffset, allocOldSrc, allocSlotValid} = aP;
    lookupValid = lV;
    lookupKey = lK;
    cnt = 0;
    hitRow = -1;
    freeRow = -1;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (mValid[r]) cnt++;
      else freeRow = r;
      if (mValid[r] && mKey[r] == lK) hitRow = r;
    end
    it.ready = (cnt < ROWS);
    it.hit = lV && (hitRow >= 0);
    it.pay = it.hit ? mPay[hitRow] : '0;
    it.tag = tag;
    #(CLK_PERIOD/4);
    expQ.push_back(it);
    if (it.hit) mValid[hitRow] = 1'b0;
    if (aV && it.ready) begin
      mValid[freeRow] = 1'b1;
      mKey[freeRow] = aK;
      mPay[freeRow] = aP;
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, '0, 1'b0, '0, tag);
  endtask

  // monitor: compares design outputs against queued expectations
  initial begin
    expItem_t got;
    forever begin
      wait (expQ.size() > 0);
      got = expQ.pop_front();
      total++;
      if (allocReady !== got.ready) begin
        bad++;
        $display("FAIL %s allocReady actual=%0b expected=%0b", got.tag, allocReady, got.ready);
      end
      total++;
      if (lookupHit !== got.hit) begin
        bad++;
        $display("FAIL %s lookupHit actual=%0b expected=%0b", got.tag, lookupHit, got.hit);
      end
      total++;
      if ({rdSize, rdOffset, rdOldSrc, rdSlotValid} !== got.pay) begin
        bad++;
        $display("FAIL %s read data actual=%h expected=%h", got.tag,
                 {rdSize, rdOffset, rdOldSrc, rdSlotValid}, got.pay);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [PAY_W-1:0] pA;
    logic [PAY_W-1:0] pB;
    for (int r = 0; r < ROWS; r++) begin
      mValid[r] = 1'b0;
      mKey[r] = '0;
      mPay[r] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R4: empty after reset, stored key 0 must not hit
    idle("R1 reset state");
    step(1'b0, '0, '0, 1'b1, 4'd0, "R1 R4 key0 after reset");

    // R7: partial slots with distinct fields
    pA = mkPay(8'b0100_0101);
    step(1'b1, 4'd5, pA, 1'b0, '0, "R7 alloc key5");
    step(1'b0, '0, '0, 1'b0, 4'd5, "R8 lookupValid low");
    step(1'b0, '0, '0, 1'b1, 4'd5, "R3 R7 hit key5");
    step(1'b0, '0, '0, 1'b1, 4'd5, "R5 R4 repeat key5 misses");

    // R2: fill every row, then offer one more
    for (int k = 1; k <= ROWS; k++)
      step(1'b1, KEY_W'(k), mkPay(SLOTS'($urandom)), 1'b0, '0, "R2 fill");
    step(1'b1, 4'd9, mkPay(8'hff), 1'b0, '0, "R2 full refuses");
    step(1'b0, '0, '0, 1'b1, 4'd9, "R2 dropped alloc absent");
    step(1'b0, '0, '0, 1'b1, 4'd2, "R3 free key2");
    idle("R2 ready again");

    // R6: allocate and release together
    step(1'b1, 4'd8, mkPay(8'h3c), 1'b1, 4'd3, "R6 alloc+lookup");
    step(1'b0, '0, '0, 1'b1, 4'd3, "R6 released row misses");
    step(1'b0, '0, '0, 1'b1, 4'd8, "R6 new row hits");

    // R9: duplicate keys return in row order
    pB = mkPay(8'h0f);
    step(1'b1, 4'd6, pB, 1'b1, 4'd1, "R9 free key1, alloc dup A");
    step(1'b1, 4'd6, mkPay(8'hf0), 1'b0, '0, "R9 alloc dup B");
    step(1'b0, '0, '0, 1'b1, 4'd6, "R9 lowest dup first");
    step(1'b0, '0, '0, 1'b1, 4'd6, "R9 second dup next");
    step(1'b0, '0, '0, 1'b1, 4'd6, "R9 dups exhausted");

    // R6 mixed random traffic, narrow key range
    for (int n = 0; n < 300; n++)
      step(1'($urandom), KEY_W'($urandom % 4), mkPay(SLOTS'($urandom)),
           1'($urandom), KEY_W'($urandom % 4), "R6 random");

    @(negedge clk);
    wait (expQ.size() == 0);
    #1;
    finish_run();
  end
endmodule